// File: doc/BRIEF.md
# Atomic memory operation unit

This unit executes the 32-bit atomic instruction group of a RISC-V core: load-reserved, store-conditional and nine read-modify-write operations. The core hands over an instruction word together with the value of the address register (rs1) and the operand register (rs2) through a valid/ready handshake. The unit decodes the word and runs the memory traffic on a single-port request/grant interface. It finishes with a one-cycle done pulse that carries a destination-register write request or an illegal-instruction flag.

A read-modify-write runs as a read phase and then a write phase to the same address. The unit accepts nothing new until the write phase has been granted. Load-reserved records one reservation, held as a valid bit and an address. Store-conditional succeeds only against a matching valid reservation, and it clears the reservation whatever the outcome.

Top module: `amo_unit`

## Requirements
- R1: Only opcode bits[6:0] = 0101111 with funct3 bits[14:12] = 010 are accepted. Any other word completes with `illegal` = 1 and `rd_we` = 0, and it issues no memory request.
- R2: funct5 (bits[31:27]) selects the operation: 00010 LR, 00011 SC, 00001 SWAP, 00000 ADD, 00100 XOR, 01100 AND, 01000 OR, 10000 MIN, 10100 MAX, 11000 MINU, 11100 MAXU. Any other funct5 is illegal as in R1.
- R3: LR with a nonzero rs2 field (bits[24:20]) is illegal. Otherwise LR reads the word at rs1, returns it as `rd_data` and records rs1 as the valid reservation.
- R4: SC whose rs1 equals the address of a valid reservation writes rs2 to rs1 and returns 0.
- R5: SC without a valid matching reservation returns 1 and issues no memory request.
- R6: Every SC leaves the reservation invalid, so a second SC to the same address fails.
- R7: SWAP, ADD, XOR, AND and OR read the old word, then write old op rs2 to the same address (rs2 itself for SWAP, ADD modulo 2^32), and return the old word.
- R8: MIN and MAX compare old word and rs2 as signed 32-bit values. MINU and MAXU compare them as unsigned values. The selected value is written back and the old word is returned.
- R9: When the rd field (bits[11:7]) is 0, `rd_we` stays 0. An AMO still performs its memory write.
- R10: `in_ready` is 1 only while idle. A pending memory request keeps address, direction and data stable until `mem_gnt`. Each instruction ends with `done` high for exactly one cycle.
- R11: After reset the unit is idle with no memory request, no `done`, and no valid reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered by the core |
| in_ready | output | 1 | Unit idle and able to take an instruction |
| in_instr | input | 32 | Instruction word |
| in_rs1 | input | 32 | Address register value |
| in_rs2 | input | 32 | Operand register value |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Access completes in this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the grant cycle |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | With done: instruction was illegal |
| rd_we | output | 1 | With done: write rd_data to register rd_idx |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 32 | Destination value |

## Verification
Each of the nine read-modify-write operations is driven with operand pairs that separate it from its neighbours. These include an addition that carries out of bit 31 and a pair with the sign bit set, so that the signed and unsigned compares give opposite picks. Reservation sequences cover SC with no reservation, SC to a different address, SC after a matching LR, and a repeated SC. Together they separate success from failure and show that every SC clears the reservation. Illegal encodings are tried in each decoded field, and a slow grant pattern shows that requests are held and that the unit refuses new work while busy.

// File: rtl/amo_pkg.sv
package amo_pkg;
    typedef enum logic [3:0] {
        OP_LR, OP_SC, OP_SWAP, OP_ADD, OP_XOR, OP_AND, OP_OR,
        OP_MIN, OP_MAX, OP_MINU, OP_MAXU
    } amo_op_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_READ, ST_WRITE, ST_RESP
    } amo_st_e;

    localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
    localparam logic [2:0] F3_WORD    = 3'b010;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [31:0] instr,
    output amo_op_e     op,
    output logic        bad,
    output logic [4:0]  rd
);
    logic [4:0] f5;
    logic [4:0] rs2f;

    always_comb begin
        f5   = instr[31:27];
        rs2f = instr[24:20];
        rd   = instr[11:7];
        bad  = 1'b0;
        op   = OP_ADD;
        case (f5)
            5'b00010: begin op = OP_LR; bad = (rs2f != 5'd0); end
            5'b00011: op = OP_SC;
            5'b00001: op = OP_SWAP;
            5'b00000: op = OP_ADD;
            5'b00100: op = OP_XOR;
            5'b01100: op = OP_AND;
            5'b01000: op = OP_OR;
            5'b10000: op = OP_MIN;
            5'b10100: op = OP_MAX;
            5'b11000: op = OP_MINU;
            5'b11100: op = OP_MAXU;
            default:  bad = 1'b1;
        endcase
        if (instr[6:0] != OPC_ATOMIC || instr[14:12] != F3_WORD)
            bad = 1'b1;
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int W = 32
) (
    input  amo_op_e      op,
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] res
);
    logic s_lt;
    logic u_lt;

    always_comb begin
        s_lt = $signed(old_val) < $signed(opnd);
        u_lt = old_val < opnd;
        case (op)
            OP_SWAP: res = opnd;
            OP_ADD:  res = old_val + opnd;
            OP_XOR:  res = old_val ^ opnd;
            OP_AND:  res = old_val & opnd;
            OP_OR:   res = old_val | opnd;
            OP_MIN:  res = s_lt ? old_val : opnd;
            OP_MAX:  res = s_lt ? opnd : old_val;
            OP_MINU: res = u_lt ? old_val : opnd;
            OP_MAXU: res = u_lt ? opnd : old_val;
            default: res = opnd;
        endcase
    end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [31:0]  in_instr,
    input  logic [W-1:0] in_rs1,
    input  logic [W-1:0] in_rs2,
    output logic         mem_req,
    input  logic         mem_gnt,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    output logic         done,
    output logic         illegal,
    output logic         rd_we,
    output logic [4:0]   rd_idx,
    output logic [W-1:0] rd_data
);
    typedef struct packed {
        amo_st_e      st;
        amo_op_e      op;
        logic [W-1:0] addr;
        logic [W-1:0] opnd;
        logic [W-1:0] wdata;
        logic [W-1:0] result;
        logic [4:0]   rd;
        logic         bad;
        logic         wr_rd;
        logic         resv_valid;
        logic [W-1:0] resv_addr;
    } state_t;

    state_t s_d, s_q;

    amo_op_e      dec_op;
    logic         dec_bad;
    logic [4:0]   dec_rd;
    logic [W-1:0] alu_res;
    logic         accept;

    amo_decode u_dec (
        .instr (in_instr),
        .op    (dec_op),
        .bad   (dec_bad),
        .rd    (dec_rd)
    );

    amo_alu #(.W(W)) u_alu (
        .op      (s_q.op),
        .old_val (mem_rdata),
        .opnd    (s_q.opnd),
        .res     (alu_res)
    );

    assign accept = in_valid && (s_q.st == ST_IDLE);

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    s_d.op    = dec_op;
                    s_d.addr  = in_rs1;
                    s_d.opnd  = in_rs2;
                    s_d.rd    = dec_rd;
                    s_d.bad   = dec_bad;
                    s_d.wr_rd = !dec_bad && (dec_rd != 5'd0);
                    if (dec_bad) begin
                        s_d.st = ST_RESP;
                    end else if (dec_op == OP_SC) begin
                        s_d.resv_valid = 1'b0;
                        if (s_q.resv_valid && s_q.resv_addr == in_rs1) begin
                            s_d.wdata  = in_rs2;
                            s_d.result = '0;
                            s_d.st     = ST_WRITE;
                        end else begin
                            s_d.result = W'(1);
                            s_d.st     = ST_RESP;
                        end
                    end else begin
                        s_d.st = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (mem_gnt) begin
                    s_d.result = mem_rdata;
                    if (s_q.op == OP_LR) begin
                        s_d.resv_valid = 1'b1;
                        s_d.resv_addr  = s_q.addr;
                        s_d.st         = ST_RESP;
                    end else begin
                        s_d.wdata = alu_res;
                        s_d.st    = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_gnt) s_d.st = ST_RESP;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, op: OP_ADD, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = (s_q.st == ST_IDLE);
    assign mem_req   = (s_q.st == ST_READ) || (s_q.st == ST_WRITE);
    assign mem_we    = (s_q.st == ST_WRITE);
    assign mem_addr  = s_q.addr;
    assign mem_wdata = s_q.wdata;
    assign done      = (s_q.st == ST_RESP);
    assign illegal   = done && s_q.bad;
    assign rd_we     = done && s_q.wr_rd;
    assign rd_idx    = s_q.rd;
    assign rd_data   = s_q.result;

    // R10
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !in_ready);
    // R9
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> rd_idx != 5'd0);
    // R1
    illegal_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !rd_we);
    // R1
    illegal_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && dec_bad |=> !mem_req);
    // R6
    sc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !dec_bad && dec_op == OP_SC |=> !s_q.resv_valid);
    // R5
    sc_fail_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !dec_bad && dec_op == OP_SC && !(s_q.resv_valid && s_q.resv_addr == in_rs1)
        |=> !mem_req && done && rd_data == W'(1));
endmodule

// File: tb/amo_unit_tb.sv
module amo_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0, in_rs1 = '0, in_rs2 = '0;
    logic        mem_req, mem_gnt, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, illegal, rd_we;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data;

    logic [31:0] mem [16];
    logic        slow = 1'b0;
    logic [7:0]  cyc = '0;
    int          nreq = 0, nwr = 0;
    int          tests = 0, fails = 0;
    logic        r_we, r_ill, r_busy;
    logic [31:0] r_data;
    logic [4:0]  r_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    amo_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .illegal(illegal),
        .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    assign mem_gnt   = slow ? cyc[1] : 1'b1;
    assign mem_rdata = mem[mem_addr[5:2]];

    always @(posedge clk) begin
        cyc <= cyc + 8'd1;
        if (mem_req && mem_gnt) begin
            nreq = nreq + 1;
            if (mem_we) begin
                nwr = nwr + 1;
                mem[mem_addr[5:2]] = mem_wdata;
            end
        end
    end

    function automatic logic [31:0] mk(input logic [4:0] f5, input logic [4:0] rs2f,
                                       input logic [2:0] f3, input logic [4:0] rd,
                                       input logic [6:0] opc);
        return {f5, 2'b00, rs2f, 5'd1, f3, rd, opc};
    endfunction

    function automatic logic [31:0] amo(input logic [4:0] f5, input logic [4:0] rd);
        return mk(f5, 5'd2, 3'b010, rd, 7'b0101111);
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic exec(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        int t;
        nreq = 0; nwr = 0;
        @(negedge clk);
        in_instr = ins; in_rs1 = a; in_rs2 = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        r_busy = in_ready;
        t = 0;
        while (!done && t < 100) begin
            @(negedge clk);
            t++;
            if (!done && t == 1) r_busy = r_busy | in_ready;
        end
        chk(done, "R10 done seen", 32'(done), 1);
        r_we = rd_we; r_ill = illegal; r_data = rd_data; r_idx = rd_idx;
        @(negedge clk);
        chk(!done, "R10 done one cycle", 32'(done), 0);
    endtask

    // funct5, old memory word, rs2, expected write-back
    localparam logic [100:0] VEC [10] = '{
        {5'b00001, 32'h11112222, 32'hAAAA5555, 32'hAAAA5555},
        {5'b00000, 32'hFFFFFFFF, 32'h00000002, 32'h00000001},
        {5'b00100, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0},
        {5'b01100, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000},
        {5'b01000, 32'hF0F0F0F0, 32'h0F000000, 32'hFFF0F0F0},
        {5'b10000, 32'h80000000, 32'h00000001, 32'h80000000},
        {5'b10100, 32'h80000000, 32'h00000001, 32'h00000001},
        {5'b11000, 32'h80000000, 32'h00000001, 32'h00000001},
        {5'b11100, 32'h80000000, 32'h00000001, 32'h80000000},
        {5'b10000, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'hFFFFFFFE}
    };

    initial begin
        #(CLK_PERIOD * 100000);
        fails++; tests++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h100 + 32'(i);
        #(CLK_PERIOD * 3);
        @(negedge clk);
        // R11 reset state
        chk(in_ready && !mem_req && !done, "R11 reset idle", {29'd0, in_ready, mem_req, done}, 32'h4);
        rst_n = 1'b1;
        // R11 no reservation after reset: SC fails
        exec(amo(5'b00011, 5'd3), 32'h20, 32'h55);
        chk(r_data == 1 && r_we, "R11 sc after reset", r_data, 1);
        // R5 failed SC: no memory request
        chk(nreq == 0, "R5 no request", 32'(nreq), 0);

        // R7 R8 table
        for (int i = 0; i < 10; i++) begin
            mem[4] = VEC[i][95:64];
            exec(amo(VEC[i][100:96], 5'd5), 32'h10, VEC[i][63:32]);
            chk(r_data == VEC[i][95:64] && r_we && r_idx == 5, "R7 old value", r_data, VEC[i][95:64]);
            chk(mem[4] == VEC[i][31:0], "R8 R7 written value", mem[4], VEC[i][31:0]);
            chk(nreq == 2 && nwr == 1, "R7 read then write", 32'(nreq), 2);
        end

        // R3 LR loads and reserves
        mem[8] = 32'hCAFE0001;
        exec(amo(5'b00010, 5'd6) & ~32'h01F00000, 32'h20, 0);
        chk(r_data == 32'hCAFE0001 && r_we && !r_ill, "R3 lr load", r_data, 32'hCAFE0001);
        // R5 SC to other address fails, and clears reservation (R6)
        exec(amo(5'b00011, 5'd7), 32'h24, 32'h77);
        chk(r_data == 1 && nreq == 0 && mem[9] == 32'h109, "R5 sc mismatch", r_data, 1);
        exec(amo(5'b00011, 5'd7), 32'h20, 32'h77);
        chk(r_data == 1 && mem[8] == 32'hCAFE0001, "R6 cleared by failed sc", r_data, 1);
        // R4 success
        exec(amo(5'b00010, 5'd6) & ~32'h01F00000, 32'h20, 0);
        exec(amo(5'b00011, 5'd7), 32'h20, 32'h12345678);
        chk(r_data == 0 && r_we && mem[8] == 32'h12345678 && nwr == 1, "R4 sc success", r_data, 0);
        // R6 second SC fails
        exec(amo(5'b00011, 5'd7), 32'h20, 32'h9);
        chk(r_data == 1 && mem[8] == 32'h12345678, "R6 second sc fails", r_data, 1);

        // R3 LR with nonzero rs2 field illegal
        exec(amo(5'b00010, 5'd6), 32'h20, 0);
        chk(r_ill && !r_we && nreq == 0, "R3 lr rs2 illegal", 32'(r_ill), 1);
        // R1 bad funct3, bad opcode
        exec(mk(5'b00000, 5'd2, 3'b011, 5'd5, 7'b0101111), 32'h10, 1);
        chk(r_ill && !r_we && nreq == 0, "R1 funct3 illegal", 32'(r_ill), 1);
        exec(mk(5'b00000, 5'd2, 3'b010, 5'd5, 7'b0110011), 32'h10, 1);
        chk(r_ill && !r_we && nreq == 0, "R1 opcode illegal", 32'(r_ill), 1);
        // R2 unlisted funct5
        exec(amo(5'b00101, 5'd5), 32'h10, 1);
        chk(r_ill && !r_we && nreq == 0, "R2 funct5 illegal", 32'(r_ill), 1);

        // R9 rd = x0
        mem[3] = 32'd40;
        exec(amo(5'b00000, 5'd0), 32'h0C, 32'd2);
        chk(!r_we && mem[3] == 32'd42, "R9 x0 no write", {31'd0, r_we}, 0);

        // R10 slow grant, busy refuses
        slow = 1'b1;
        mem[5] = 32'd7;
        exec(amo(5'b00000, 5'd9), 32'h14, 32'd5);
        chk(r_data == 7 && mem[5] == 12 && !r_busy, "R10 slow grant add", mem[5], 12);
        slow = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule